// File: doc/BRIEF.md
# Collision Vector Pipeline Initiation Controller

This controller decides, cycle by cycle, whether a new task may enter a static pipeline that never stalls internally. It keeps a collision vector in a shift register. Bit i (counting from 1 at the least significant end) set to 1 means that starting a task i cycles after the previous start would make two tasks use the same stage in the same cycle. In each cycle the register shifts right by one, so its least significant bit always tells whether starting now is safe. A granted start ORs the initial collision vector back into the shifted register. The register therefore walks the states of the collision-vector state diagram. An empty pipeline is the all-zero vector.

The controller has two issue modes. In greedy mode a pending request is granted at the first safe cycle, which gives the minimum-latency issue pattern. In explicit mode the caller also sets a minimum latency, and a request is granted only once that many cycles have passed and the cycle is safe. The outputs are the current vector, the number of cycles since the last start (saturating at width+1, where every later start behaves the same), and the latency of the most recent grant, so that the issue sequence can be compared with an expected latency cycle.

Top module: `cvic_initiation_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge, cv_state becomes all zeros, since_cnt becomes N+1 (6 for the default N=5), last_lat becomes 0, and grant stays low.
- R2: grant is high only when req is high and cv_state[0] (the latency-1 position) is 0.
- R3: After a cycle with grant high, cv_state equals the previous cv_state shifted right by one (zero filled at the top) ORed with icv.
- R4: After a cycle with grant low, cv_state equals the previous cv_state shifted right by one with a zero at the top.
- R5: The all-zero state persists for any number of cycles while req is low.
- R6: In greedy mode (mode_explicit = 0), grant is high in every cycle where req is high and cv_state[0] is 0.
- R7: In explicit mode (mode_explicit = 1), grant is high exactly when req is high, cv_state[0] is 0 and since_cnt >= min_lat.
- R8: since_cnt is 1 in the cycle after a grant, increments by one in each cycle without a grant, and saturates at N+1.
- R9: After a grant, last_lat holds the since_cnt value of the granting cycle until the next grant.
- R10: With icv = 5'b10010 and req held high in greedy mode from an empty pipeline, the grant latencies after the first one repeat 1,3,3 (7 cycles per 3 starts), and the state after each grant is one of 10010, 11011 or 10011.
- R11: A grant at a latency of N+1 or more leaves cv_state equal to icv.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| icv | input | N | Initial collision vector; bit 0 is latency 1 |
| req | input | 1 | Initiation request |
| mode_explicit | input | 1 | 0 = greedy issue, 1 = explicit minimum-latency issue |
| min_lat | input | CW | Minimum latency used in explicit mode |
| grant | output | 1 | Start permitted in this cycle (combinational pulse) |
| cv_state | output | N | Current collision vector |
| since_cnt | output | CW | Latency a start in this cycle would have, saturating at N+1 |
| last_lat | output | CW | Latency of the most recent grant |

## Verification
The bench drives the ICV 10010 greedy case from an empty pipeline. A controller that merged the vector before shifting, or tested the wrong bit, would leave the 1,3,3 cycle and visit states outside {10010, 11011, 10011}. Explicit mode is run with a minimum latency that is forbidden (2), so the grant has to slip to 3, and with an allowed one (4). A controller that ignored the forbidden bit or the minimum would show other latencies. Long idle gaps check that the gap counter saturates rather than wrapping and that a late start resets the state to exactly the ICV. A reset in the middle of a run followed by a second ICV checks that no old state survives.

// File: rtl/cvic_pkg.sv
// Package: shared types for the collision-vector initiation controller.
// Assumes nothing beyond IEEE 1800-2017.
package cvic_pkg;
    typedef enum logic {
        ISSUE_GREEDY   = 1'b0,
        ISSUE_EXPLICIT = 1'b1
    } issue_mode_e;
endpackage

// File: rtl/cvic_state_reg.sv
// Collision vector register. Each cycle it shifts right by one with a zero
// entering at the top; when load is high the initial vector is ORed in.
// Assumes bit 0 is the latency-1 position and load is already qualified.
module cvic_state_reg #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] icv,
    input  logic         load,
    output logic [N-1:0] cv
);
    logic [N-1:0] cv_q;
    logic [N-1:0] cv_d;

    // Per-bit next state: upper neighbour (zero at top) merged with icv on load.
    for (genvar j = 0; j < N; j++) begin : g_bit
        if (j == N - 1) begin : g_top
            assign cv_d[j] = load & icv[j];
        end else begin : g_mid
            assign cv_d[j] = cv_q[j+1] | (load & icv[j]);
        end
    end

    // State register with synchronous clear to the empty-pipeline vector.
    always_ff @(posedge clk) begin
        if (!rst_n) cv_q <= '0;
        else        cv_q <= cv_d;
    end

    assign cv = cv_q;

    // R4: without a load the vector only shifts.
    p_shift_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> cv == ($past(cv) >> 1));
    // R3: with a load the shifted vector is merged with icv.
    p_merge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cv == (($past(cv) >> 1) | $past(icv)));
endmodule

// File: rtl/cvic_gap_counter.sv
// Counts the cycles since the last initiation (the latency a start now would
// have), saturating at N+1, and keeps the latency of the last grant.
// Assumes load marks a granted initiation in the current cycle.
module cvic_gap_counter #(
    parameter int N  = 5,
    parameter int CW = $clog2(N + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    output logic [CW-1:0] since,
    output logic [CW-1:0] last
);
    localparam logic [CW-1:0] SAT = CW'(N + 1);

    logic [CW-1:0] since_q;
    logic [CW-1:0] last_q;

    // Gap counter: restart at 1 after a grant, else count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_q <= SAT;
        else if (load)           since_q <= CW'(1);
        else if (since_q != SAT) since_q <= since_q + CW'(1);
    end

    // Capture the latency of each granted initiation.
    always_ff @(posedge clk) begin
        if (!rst_n)    last_q <= '0;
        else if (load) last_q <= since_q;
    end

    assign since = since_q;
    assign last  = last_q;

    // R8: the counter restarts at one after a grant.
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> since == CW'(1));
    // R8: the counter never passes its saturation value.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        since <= SAT);
endmodule

// File: rtl/cvic_issue_ctl.sv
// Issue decision: grants a pending request when the latency-1 bit of the
// current vector is free and, in explicit mode, the minimum latency is met.
// Assumes cv_lsb and since come from registers; the output is combinational.
module cvic_issue_ctl
    import cvic_pkg::*;
#(
    parameter int N  = 5,
    parameter int CW = $clog2(N + 2)
) (
    input  logic          rst_n,
    input  logic          req,
    input  issue_mode_e   mode,
    input  logic [CW-1:0] min_lat,
    input  logic          cv_lsb,
    input  logic [CW-1:0] since,
    output logic          grant
);
    logic lat_ok;

    // Minimum-latency gate: always open in greedy mode.
    always_comb begin
        unique case (mode)
            ISSUE_GREEDY:   lat_ok = 1'b1;
            ISSUE_EXPLICIT: lat_ok = (since >= min_lat);
            default:        lat_ok = 1'b0;
        endcase
    end

    // Grant: request pending, no collision, latency accepted, not in reset.
    always_comb grant = rst_n & req & ~cv_lsb & lat_ok;
endmodule

// File: rtl/cvic_initiation_ctrl.sv
// Top: collision-vector pipeline initiation controller. It walks the
// collision-vector state diagram in hardware and issues starts greedily or at
// a requested minimum latency.
// Assumes a static pipeline with no internal stalls, icv bit 0 = latency 1,
// and icv stable between initiations.
module cvic_initiation_ctrl
    import cvic_pkg::*;
#(
    parameter int N  = 5,
    parameter int CW = $clog2(N + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  icv,
    input  logic          req,
    input  logic          mode_explicit,
    input  logic [CW-1:0] min_lat,
    output logic          grant,
    output logic [N-1:0]  cv_state,
    output logic [CW-1:0] since_cnt,
    output logic [CW-1:0] last_lat
);
    issue_mode_e mode;
    logic        grant_w;

    // Mode decode from the plain port.
    always_comb mode = issue_mode_e'(mode_explicit);

    cvic_issue_ctl #(.N(N), .CW(CW)) u_issue (
        .rst_n   (rst_n),
        .req     (req),
        .mode    (mode),
        .min_lat (min_lat),
        .cv_lsb  (cv_state[0]),
        .since   (since_cnt),
        .grant   (grant_w)
    );

    cvic_state_reg #(.N(N)) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .icv   (icv),
        .load  (grant_w),
        .cv    (cv_state)
    );

    cvic_gap_counter #(.N(N), .CW(CW)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (grant_w),
        .since (since_cnt),
        .last  (last_lat)
    );

    assign grant = grant_w;

    // R2: never grant into a collision or without a request.
    p_safe_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (req && !cv_state[0]));
    // R7: explicit mode never starts before the requested latency.
    p_explicit_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && mode_explicit) |-> (since_cnt >= min_lat));
    // R9: the reported latency is the gap at the granting cycle.
    p_last_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> last_lat == $past(since_cnt));
    // R5: an empty pipeline stays empty while no request arrives.
    p_empty_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_state == '0 && !req) |=> cv_state == '0);
    // R11: a start at a saturated gap loads exactly the initial vector.
    p_late_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && since_cnt == CW'(N + 1)) |=> cv_state == $past(icv));
endmodule

// File: tb/sim_cvic_initiation_ctrl.sv
`timescale 1ns/100ps
module sim_cvic_initiation_ctrl;
    localparam int N  = 5;
    localparam int CW = $clog2(N + 2);
    localparam logic [CW-1:0] SAT = CW'(N + 1);

    typedef struct {
        logic          g;
        logic [N-1:0]  cv;
        logic [CW-1:0] since;
        logic [CW-1:0] last;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  icv = 5'b10010;
    logic          req = 1'b0;
    logic          mode_explicit = 1'b0;
    logic [CW-1:0] min_lat = '0;
    logic          grant;
    logic [N-1:0]  cv_state;
    logic [CW-1:0] since_cnt;
    logic [CW-1:0] last_lat;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    exp_t sbq[$];
    int   lat_log[$];
    int   st_log[$];
    bit   post_grant = 0;

    // Reference model state
    logic [N-1:0]  m_cv;
    logic [CW-1:0] m_since;
    logic [CW-1:0] m_last;

    always #2 clk = ~clk;

    cvic_initiation_ctrl #(.N(N), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .icv(icv), .req(req),
        .mode_explicit(mode_explicit), .min_lat(min_lat), .grant(grant),
        .cv_state(cv_state), .since_cnt(since_cnt), .last_lat(last_lat)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cv = '0; m_since = SAT; m_last = '0;
    endtask

    // Driver: apply one cycle of stimulus, predict outputs, push to scoreboard.
    task automatic step(input logic r, input logic mx, input logic [CW-1:0] ml, input string tag);
        exp_t e;
        @(negedge clk);
        req = r; mode_explicit = mx; min_lat = ml;
        #0.5;
        e.g     = r && !m_cv[0] && (!mx || m_since >= ml);
        e.cv    = m_cv;
        e.since = m_since;
        e.last  = m_last;
        e.tag   = tag;
        sbq.push_back(e);
        m_cv    = (m_cv >> 1) | (e.g ? icv : '0);
        m_last  = e.g ? m_since : m_last;
        m_since = e.g ? CW'(1) : ((m_since == SAT) ? SAT : m_since + CW'(1));
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst_n = 1'b0; req = 1'b0;
        repeat (cycles) @(negedge clk);
        #0.5;
        // R1: reset state at the ports
        check(cv_state == '0, "R1 cv_state", cv_state, 0);
        check(since_cnt == SAT, "R1 since_cnt", since_cnt, SAT);
        check(last_lat == '0, "R1 last_lat", last_lat, 0);
        check(grant == 1'b0, "R1 grant", grant, 0);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Monitor: pop expected items and compare with the design's outputs.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                check(grant == e.g, {e.tag, " R2 grant"}, grant, e.g);
                check(cv_state == e.cv, {e.tag, " R3 R4 cv_state"}, cv_state, e.cv);
                check(since_cnt == e.since, {e.tag, " R8 since_cnt"}, since_cnt, e.since);
                check(last_lat == e.last, {e.tag, " R9 last_lat"}, last_lat, e.last);
                if (post_grant) st_log.push_back(int'(cv_state));
                post_grant = grant;
                if (grant) lat_log.push_back(int'(since_cnt));
            end else begin
                post_grant = 0;
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset(3);

        // R5: empty pipeline holds with no request
        repeat (4) step(1'b0, 1'b0, '0, "R5");

        // R6 R10: greedy issue from empty pipeline with icv 10010
        lat_log.delete(); st_log.delete();
        repeat (22) step(1'b1, 1'b0, '0, "R6");
        repeat (2) step(1'b0, 1'b0, '0, "R4");
        check(lat_log.size() >= 7, "R10 grant count", lat_log.size(), 7);
        if (lat_log.size() >= 7) begin
            check(lat_log[0] == 6, "R10 first latency", lat_log[0], 6);
            for (int k = 1; k < 7; k++)
                check(lat_log[k] == ((k % 3 == 1) ? 1 : 3), "R10 latency cycle",
                      lat_log[k], (k % 3 == 1) ? 1 : 3);
        end
        for (int k = 0; k < st_log.size(); k++)
            check(st_log[k] == 5'b10010 || st_log[k] == 5'b11011 || st_log[k] == 5'b10011,
                  "R10 state set", st_log[k], 5'b10010);

        // R8: gap counter saturates at N+1 after a long idle
        repeat (9) step(1'b0, 1'b0, '0, "R8");
        #1.5;
        check(since_cnt == SAT, "R8 saturation", since_cnt, SAT);
        check(cv_state == '0, "R5 drained", cv_state, 0);

        // R7: explicit mode with a forbidden minimum (2) slips to 3
        lat_log.delete();
        repeat (14) step(1'b1, 1'b1, CW'(2), "R7");
        check(lat_log.size() >= 3, "R7 grant count", lat_log.size(), 3);
        for (int k = 1; k < lat_log.size(); k++)
            check(lat_log[k] == 3, "R7 min 2 latency", lat_log[k], 3);

        // R7: explicit mode with an allowed minimum (4)
        lat_log.delete();
        repeat (16) step(1'b1, 1'b1, CW'(4), "R7");
        check(lat_log.size() >= 3, "R7 grant count min4", lat_log.size(), 3);
        for (int k = 1; k < lat_log.size(); k++)
            check(lat_log[k] == 4, "R7 min 4 latency", lat_log[k], 4);

        // R11: start at latency N+1 loads exactly icv
        repeat (N) step(1'b0, 1'b0, '0, "R11");
        st_log.delete();
        step(1'b1, 1'b1, SAT, "R11");
        step(1'b0, 1'b0, '0, "R11");
        step(1'b0, 1'b0, '0, "R11");
        check(st_log.size() == 1, "R11 grant seen", st_log.size(), 1);
        if (st_log.size() == 1)
            check(st_log[0] == int'(icv), "R11 state equals icv", st_log[0], icv);

        // R1 R6: reset mid-run, then greedy with another vector
        do_reset(2);
        icv = 5'b00101;
        repeat (18) step(1'b1, 1'b0, '0, "R6");
        repeat (3) step(1'b0, 1'b0, '0, "R4");
        repeat (6) step(1'b1, 1'b1, CW'(5), "R7");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule